// File: doc/BRIEF.md
# Sigma-Delta Bitstream Serial Receiver

This block is the input front end of one channel that listens to an external sigma-delta modulator. It takes the modulator's one-bit stream and turns it into single-bit samples, each marked by a one-cycle valid strobe, in the domain of a fast system clock. Downstream decimation logic consumes these samples. Decimation, offset handling and overload detection are not part of this block.

The stream can arrive in one of two forms. In the first, a serial clock comes with the data and the block samples the data on a chosen edge of that clock. In the second, the data is Manchester coded on the data line alone and decoded in either polarity. For the clocked form, the serial clock comes either from an external pin or from the modulator clock that the chip supplies. Two further modes sample on every second edge of that supplied clock. They serve modulators that divide their input clock by two.

A four-bit configuration word selects the source and the format. It can be written only while the channel is disabled. The serial clock and the data input each pass through a two-flop synchronizer. All edges are detected in the system clock domain, which must run at least four times faster than the serial clock.

Top module: `sdBitRx`

## Requirements
- R1: After reset the configuration reads back as 0 (external clock, rising-edge sampling) and `sampleValid` is low.
- R2: With source field 0, the external clock `serClkIn` is used. Format 00 samples `serDataIn` on its rising edges and format 01 samples it on its falling edges. Each accepted edge gives exactly one sample, in stream order.
- R3: With source field 1, the supplied clock `modClk` is used, and formats 00 and 01 pick the sampling edge as in R2.
- R4: With source field 2, a sample is taken on every second falling edge of `modClk`. Counting starts at the enable, so the first sample falls on the second falling edge.
- R5: With source field 3, a sample is taken on every second rising edge of `modClk`. The first sample falls on the second rising edge after the enable.
- R6: Format 10 decodes Manchester data in which a mid-bit rising transition means 0 and a falling transition means 1.
- R7: Format 11 decodes Manchester data in which a rising transition means 1 and a falling transition means 0.
- R8: The Manchester bit period is measured between the first two transitions after enable, and the stream must space these one bit apart. After that, a transition less than three quarters of a period after the last data transition is a bit boundary and gives no sample.
- R9: `cfgRdData` shows the source field in bits [3:2] and the format in bits [1:0]. A write through `cfgWrEn`/`cfgWrData` takes effect only while `chanEn` is 0 and is ignored while it is 1.
- R10: While `chanEn` is 0 no valid strobe is given. Every strobe lasts exactly one system clock cycle.
- R11: The clock source that is not selected has no effect. Edges on it produce no samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| chanEn | input | 1 | Channel enable |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 4 | Configuration word: [3:2] clock source, [1:0] format |
| cfgRdData | output | 4 | Current configuration word |
| serClkIn | input | 1 | External serial clock |
| modClk | input | 1 | Supplied modulator clock, as seen by this block |
| serDataIn | input | 1 | Serial or Manchester data line |
| sampleValid | output | 1 | One-cycle strobe for each accepted sample |
| sampleBit | output | 1 | Sampled bit, valid with `sampleValid` |

## Verification
The assertions assume the following about the serial inputs:
- Neither clock line nor the data line changes faster than once every four system clock cycles.
- The configuration is stable whenever the channel is enabled.
- A Manchester stream starts with two bits of opposite value.

The single-cycle strobe property and the divide-by-two toggle checks both depend on this input pacing. The bench meets these conditions as follows:
- Every modelled modulator holds each level for four cycles in clocked modes and eight cycles per half bit in Manchester mode.
- The configuration is written only while the channel is disabled.
- Every Manchester word is chosen with differing first two bits.

// File: rtl/sdrx_pkg.sv
package sdrx_pkg;
  localparam int SEL_W = 2;
  localparam int IF_W  = 2;
  localparam int CFG_W = SEL_W + IF_W;

  typedef enum logic [SEL_W-1:0] {
    CK_EXT       = 2'd0,
    CK_MOD       = 2'd1,
    CK_MOD_DIV_F = 2'd2,
    CK_MOD_DIV_R = 2'd3
  } clkSelE;

  typedef enum logic [1:0] {
    M_WAIT    = 2'd0,
    M_MEASURE = 2'd1,
    M_LOCKED  = 2'd2
  } manPhaseE;

  typedef struct packed {
    logic extRise;
    logic extFall;
    logic modRise;
    logic modFall;
    logic datRise;
    logic datFall;
  } rxEdgeT;

  typedef struct packed {
    logic capture;
    logic useManch;
    logic manchBit;
  } rxStrobeT;
endpackage

// File: rtl/sdrxDatapath.sv
module sdrxDatapath
  import sdrx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     chanEn,
  input  logic     serClkIn,
  input  logic     modClk,
  input  logic     serDataIn,
  input  rxStrobeT strb,
  output rxEdgeT   edges,
  output logic     sampleValid,
  output logic     sampleBit
);
  localparam int LINES = 3;

  logic [LINES-1:0] rawIn;
  logic [SYNC_STAGES-1:0][LINES-1:0] syncPipe;
  logic [LINES-1:0] cur, prev, rise, fall;

  assign rawIn = {serDataIn, modClk, serClkIn};
  assign cur   = syncPipe[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncPipe <= '0;
      prev     <= '0;
    end else begin
      syncPipe <= {syncPipe[SYNC_STAGES-2:0], rawIn};
      prev     <= cur;
    end
  end

  for (genvar i = 0; i < LINES; i++) begin : g_edge
    assign rise[i] = cur[i] & ~prev[i];
    assign fall[i] = ~cur[i] & prev[i];
  end

  assign edges = '{extRise: rise[0], extFall: fall[0],
                   modRise: rise[1], modFall: fall[1],
                   datRise: rise[2], datFall: fall[2]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleValid <= 1'b0;
      sampleBit   <= 1'b0;
    end else begin
      sampleValid <= strb.capture & chanEn;
      if (strb.capture) sampleBit <= strb.useManch ? strb.manchBit : cur[2];
    end
  end

  p_no_valid_off_r10: assert property (@(posedge clk) disable iff (!rstN)
    !chanEn |=> !sampleValid);
  p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);
  p_manch_on_edge_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && strb.useManch) |-> (edges.datRise || edges.datFall));
endmodule

// File: rtl/sdrxControl.sv
module sdrxControl
  import sdrx_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chanEn,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  input  rxEdgeT           edges,
  output rxStrobeT         strb,
  output logic [CFG_W-1:0] cfgRdData
);
  localparam logic [CNT_W-1:0] GAP_MAX = '1;

  logic [CFG_W-1:0] cfgReg;
  clkSelE           clkSel;
  logic             isManch, fallSample;
  logic             clkHit, divMode, halfTog, clkCapture;
  manPhaseE         manPhase;
  logic [CNT_W-1:0] gapCnt, period, thresh;
  logic             datEdge, manAccept;

  assign clkSel     = clkSelE'(cfgReg[CFG_W-1:IF_W]);
  assign isManch    = cfgReg[1];
  assign fallSample = cfgReg[0];
  assign cfgRdData  = cfgReg;

  always_ff @(posedge clk) begin
    if (!rstN) cfgReg <= '0;
    else if (cfgWrEn && !chanEn) cfgReg <= cfgWrData;
  end

  always_comb begin
    divMode = 1'b0;
    unique case (clkSel)
      CK_EXT:       clkHit = fallSample ? edges.extFall : edges.extRise;
      CK_MOD:       clkHit = fallSample ? edges.modFall : edges.modRise;
      CK_MOD_DIV_F: begin clkHit = edges.modFall; divMode = 1'b1; end
      CK_MOD_DIV_R: begin clkHit = edges.modRise; divMode = 1'b1; end
      default:      clkHit = 1'b0;
    endcase
  end

  assign clkCapture = !isManch && clkHit && (!divMode || halfTog);

  always_ff @(posedge clk) begin
    if (!rstN || !chanEn) halfTog <= 1'b0;
    else if (!isManch && divMode && clkHit) halfTog <= ~halfTog;
  end

  assign datEdge   = edges.datRise | edges.datFall;
  assign thresh    = period - (period >> 2);
  assign manAccept = isManch && datEdge && (manPhase != M_LOCKED || gapCnt >= thresh);

  always_ff @(posedge clk) begin
    if (!rstN || !chanEn) begin
      manPhase <= M_WAIT;
      gapCnt   <= '0;
      period   <= '0;
    end else if (manAccept) begin
      gapCnt <= '0;
      if (manPhase == M_WAIT) manPhase <= M_MEASURE;
      else if (manPhase == M_MEASURE) begin
        manPhase <= M_LOCKED;
        period   <= gapCnt;
      end
    end else if (gapCnt != GAP_MAX) begin
      gapCnt <= gapCnt + 1'b1;
    end
  end

  assign strb = '{capture:  clkCapture | manAccept,
                  useManch: isManch,
                  manchBit: edges.datRise ? cfgReg[0] : ~cfgReg[0]};

  p_cfg_locked_r9: assert property (@(posedge clk) disable iff (!rstN)
    chanEn |=> $stable(cfgReg));
  p_toggle_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    !chanEn |=> !halfTog);
  p_div_alternate_r5: assert property (@(posedge clk) disable iff (!rstN)
    (clkCapture && divMode) |=> !halfTog);
endmodule

// File: rtl/sdBitRx.sv
module sdBitRx
  import sdrx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       chanEn,
  input  logic       cfgWrEn,
  input  logic [3:0] cfgWrData,
  output logic [3:0] cfgRdData,
  input  logic       serClkIn,
  input  logic       modClk,
  input  logic       serDataIn,
  output logic       sampleValid,
  output logic       sampleBit
);
  rxEdgeT   edges;
  rxStrobeT strb;

  sdrxControl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .chanEn(chanEn),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .edges(edges), .strb(strb), .cfgRdData(cfgRdData)
  );

  sdrxDatapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .chanEn(chanEn),
    .serClkIn(serClkIn), .modClk(modClk), .serDataIn(serDataIn),
    .strb(strb), .edges(edges),
    .sampleValid(sampleValid), .sampleBit(sampleBit)
  );
endmodule

// File: tb/tb_sdBitRx.sv
module tb_sdBitRx;
  localparam int H  = 4;
  localparam int HB = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chanEn = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [3:0] cfgWrData = '0;
  logic [3:0] cfgRdData;
  logic serClkIn = 1'b0;
  logic modClk = 1'b0;
  logic serDataIn = 1'b0;
  logic sampleValid, sampleBit;

  int checks = 0;
  int fails = 0;
  int rxCnt = 0;
  bit done = 1'b0;
  logic rxBits [64];

  always #5 clk = ~clk;

  sdBitRx dut (
    .clk(clk), .rstN(rstN), .chanEn(chanEn), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .serClkIn(serClkIn),
    .modClk(modClk), .serDataIn(serDataIn), .sampleValid(sampleValid),
    .sampleBit(sampleBit)
  );

  always @(negedge clk) begin
    if (sampleValid) begin
      if (rxCnt < 64) rxBits[rxCnt] = sampleBit;
      rxCnt++;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setCfg(logic [3:0] w);
    @(negedge clk);
    cfgWrEn = 1'b1;
    cfgWrData = w;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic checkBits(string tag, logic [15:0] w, int n);
    logic [15:0] got, mask;
    got = '0;
    mask = 16'((32'd1 << n) - 1);
    chk(rxCnt == n, {tag, " count"}, rxCnt, n);
    for (int i = 0; i < n && i < 16; i++) got[i] = rxBits[i];
    chk((got & mask) == (w & mask), {tag, " bits"}, int'(got & mask), int'(w & mask));
  endtask

  task automatic setLine(bit useMod, logic v);
    if (useMod) modClk = v;
    else serClkIn = v;
  endtask

  task automatic sendClk(bit useMod, bit fallS, bit en, logic [15:0] w, int n);
    @(negedge clk);
    setLine(useMod, fallS);
    serDataIn = w[0];
    repeat (6) @(negedge clk);
    rxCnt = 0;
    chanEn = en;
    repeat (4) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      setLine(useMod, !fallS);
      repeat (H) @(negedge clk);
      setLine(useMod, fallS);
      serDataIn = w[i + 1];
      repeat (H) @(negedge clk);
    end
    repeat (8) @(negedge clk);
    chanEn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic sendDiv(bit riseS, logic [15:0] w, int n);
    @(negedge clk);
    modClk = 1'b0;
    serDataIn = w[0];
    repeat (6) @(negedge clk);
    rxCnt = 0;
    chanEn = 1'b1;
    repeat (4) @(negedge clk);
    for (int k = 1; k <= 2 * n; k++) begin
      modClk = 1'b1;
      if (!riseS && k >= 3 && (k % 2 == 1)) serDataIn = w[(k - 1) / 2];
      repeat (H) @(negedge clk);
      modClk = 1'b0;
      if (riseS && (k % 2 == 0)) serDataIn = w[k / 2];
      repeat (H) @(negedge clk);
    end
    repeat (8) @(negedge clk);
    chanEn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic sendMan(bit pol, logic [15:0] w, int n);
    @(negedge clk);
    serDataIn = w[0] ^ pol;
    repeat (6) @(negedge clk);
    rxCnt = 0;
    chanEn = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      serDataIn = w[i] ^ pol;
      repeat (HB) @(negedge clk);
      serDataIn = ~(w[i] ^ pol);
      repeat (HB) @(negedge clk);
    end
    repeat (10) @(negedge clk);
    chanEn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(cfgRdData == 4'h0, "R1 cfg after reset", cfgRdData, 0);
    chk(sampleValid == 1'b0, "R1 valid after reset", sampleValid, 0);
  endtask

  task automatic testExt();
    setCfg(4'b0000);
    sendClk(1'b0, 1'b0, 1'b1, 16'hA5C3, 15);
    checkBits("R2 ext rising", 16'hA5C3, 15);
    setCfg(4'b0001);
    sendClk(1'b0, 1'b1, 1'b1, 16'h3C69, 15);
    checkBits("R2 ext falling", 16'h3C69, 15);
  endtask

  task automatic testMod();
    setCfg(4'b0100);
    sendClk(1'b1, 1'b0, 1'b1, 16'h5E21, 15);
    checkBits("R3 mod rising", 16'h5E21, 15);
    setCfg(4'b0101);
    sendClk(1'b1, 1'b1, 1'b1, 16'h9B74, 15);
    checkBits("R3 mod falling", 16'h9B74, 15);
  endtask

  task automatic testDiv();
    setCfg(4'b1000);
    sendDiv(1'b0, 16'h6D1B, 15);
    checkBits("R4 div falling", 16'h6D1B, 15);
    setCfg(4'b1100);
    sendDiv(1'b1, 16'h2AF6, 15);
    checkBits("R5 div rising", 16'h2AF6, 15);
  endtask

  task automatic testManch();
    setCfg(4'b0010);
    sendMan(1'b0, 16'hC3A5, 16);
    checkBits("R6 R8 manchester rise=0", 16'hC3A5, 16);
    setCfg(4'b0011);
    sendMan(1'b1, 16'h0F36, 16);
    checkBits("R7 R8 manchester rise=1", 16'h0F36, 16);
  endtask

  task automatic testCfgLock();
    setCfg(4'b0001);
    chk(cfgRdData == 4'h1, "R9 write while disabled", cfgRdData, 1);
    @(negedge clk);
    chanEn = 1'b1;
    setCfg(4'b1110);
    chk(cfgRdData == 4'h1, "R9 write while enabled ignored", cfgRdData, 1);
    chanEn = 1'b0;
    setCfg(4'b1110);
    chk(cfgRdData == 4'hE, "R9 write after disable", cfgRdData, 14);
  endtask

  task automatic testIgnore();
    setCfg(4'b0000);
    sendClk(1'b0, 1'b0, 1'b0, 16'hFFFF, 15);
    chk(rxCnt == 0, "R10 no samples while disabled", rxCnt, 0);
    sendClk(1'b1, 1'b0, 1'b1, 16'h1234, 15);
    chk(rxCnt == 0, "R11 mod clock ignored in ext mode", rxCnt, 0);
    setCfg(4'b0100);
    sendClk(1'b0, 1'b0, 1'b1, 16'h4321, 15);
    chk(rxCnt == 0, "R11 ext clock ignored in mod mode", rxCnt, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testExt();
    testMod();
    testDiv();
    testManch();
    testCfgLock();
    testIgnore();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule